// File: doc/BRIEF.md
# Phase-Toggled Block Read Streamer

This block sits on the device side of a parallel-port link and sends a run of bytes to the host. The host does not handshake each byte. It starts a block read with a command byte and a short control sequence, then steps through the bytes by flipping the lowest control bit. The block picks one of two transfer widths from the command byte.

In nibble width, the host reads each byte over the status lines. A low-fetch control value returns the low half of the byte and a high-fetch value returns the upper half. A flag tells the host when both halves are equal, so it can skip the second fetch. The host puts a marker value on its data bus before it asks for the last byte, and returns the bus to zero once it has read that byte. In byte width, the block drives the whole byte onto the data bus. The last byte has its own two-step strobe.

Bytes normally come from a show-ahead FIFO, one pop per byte. A short sequence of register writes switches the source to a built-in counting pattern, which the host uses to test the link.

Top module: `blkrd_streamer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), done_o, bus_oe_o, fifo_rd_en_o, stat_nib_o and stat_same_o are all 0.
- R2: A nibble-width read starts when the host holds command byte 0x07 on host_data_i while host_ctrl_i is 0x01 and then sets host_ctrl_i to 0x03. Any other command byte followed by 0x03 starts nothing, and later fetch values pop nothing. Control 0x01 during a nibble stream aborts it and latches a new command byte.
- R3: In a nibble stream, a low fetch (host_ctrl_i = 0x06 + phase) shows the byte's bits 3:0 on stat_nib_o. A high fetch (0x04 + phase) shows bits 7:4. stat_same_o is 1 exactly when the two halves are equal.
- R4: A new byte begins only on a low fetch (nibble) or on 0x24 + phase (byte width) whose bit 0 differs from the phase of the previous byte. The first byte uses phase 0. Each new byte pops the FIFO exactly once, one cycle after the byte is loaded.
- R5: Repeating a control value, or re-issuing a low fetch in the same phase, does not advance and does not pop. A repeated low fetch shows the low half of the same byte again.
- R6: If host_data_i is 0xFD at any time before the last nibble byte starts, that byte is marked as the final one. done_o rises when host_data_i returns to 0x00 after that byte has started. Without the marker, done_o stays 0. done_o stays 1 until the next block read starts.
- R7: A byte-width read starts with command byte 0x27 under control 0x01, then control 0x25. While the stream is active, bus_oe_o is 1 and bus_data_o carries the current byte. Bytes advance on 0x24 + phase.
- R8: In byte width, control 0x26 loads the final byte and control 0x27 then sets done_o. A control value with bit 5 clear ends the stream and drops bus_oe_o on the next cycle.
- R9: Three writes arm the test source: 0x01 to register 0x13, then 0x00 to register 0x13, then 0x11 to register 0x0A.
- R10: While the test source is on, byte index i of each block (counted from 0) is i/2 when i is even and 0xFF - (i-1)/2 when i is odd. The FIFO is never popped.
- R11: A write to register 0x0A that does not complete the arming order turns the test source off. Writes out of order, such as 0x13 = 1 followed directly by 0x0A = 0x11, do not arm it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_data_i | input | 8 | Host data bus (already synchronised) |
| host_ctrl_i | input | 6 | Host control value (already synchronised); bit 5 set means host reads |
| cfg_we_i | input | 1 | Internal register write strobe |
| cfg_addr_i | input | 5 | Internal register address |
| cfg_wdata_i | input | 8 | Internal register write data |
| fifo_rd_en_o | output | 1 | Pop pulse for the source FIFO |
| fifo_rd_data_i | input | 8 | Head of the source FIFO (show-ahead) |
| stat_nib_o | output | 4 | Nibble presented on the status lines |
| stat_same_o | output | 1 | Both halves of the current byte are equal |
| bus_oe_o | output | 1 | Drive enable for the data bus (byte width) |
| bus_data_o | output | 8 | Byte driven onto the data bus |
| done_o | output | 1 | Final byte has been delivered |

## Verification
A phase register that is out of step shows up at the FIFO port straight away. Either the next fetch produces no pop, or a repeated value produces an extra one. The status nibble then lags or leads the expected byte from the following fetch onward. A marker that was not latched, or was latched too early, shows on done_o within one host step of the data bus returning to zero. A test-source flag in the wrong state shows up on the first byte of the next block, either as a FIFO pop or as a byte that breaks the counting pattern.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_NIB,
        ST_BYTE
    } st_e;

    localparam logic [7:0] CMD_NIB   = 8'h07;
    localparam logic [7:0] CMD_BYTE  = 8'h27;
    localparam logic [7:0] MARK_VAL  = 8'hFD;
    localparam logic [7:0] END_VAL   = 8'h00;

    localparam logic [5:0] CTL_SEL     = 6'h01;
    localparam logic [5:0] CTL_NIB_GO  = 6'h03;
    localparam logic [5:0] CTL_BYTE_GO = 6'h25;
    localparam logic [5:0] CTL_FIN_A   = 6'h26;
    localparam logic [5:0] CTL_FIN_B   = 6'h27;

    localparam logic [4:0] REG_TEST_CTL = 5'h13;
    localparam logic [4:0] REG_SRC_SEL  = 5'h0A;
    localparam logic [7:0] SRC_PATTERN  = 8'h11;

    typedef struct packed {
        logic lo_fetch;
        logic hi_fetch;
        logic byte_fetch;
        logic fin_a;
        logic fin_b;
        logic phase;
        logic dir_rd;
    } ctl_ev_t;

endpackage

// File: rtl/blkrd_ctl_decode.sv
module blkrd_ctl_decode
    import blkrd_pkg::*;
(
    input  logic [5:0] ctrl_i,
    output ctl_ev_t    ev_o
);
    always_comb begin
        ev_o.lo_fetch   = (ctrl_i[5:1] == 5'b00011);
        ev_o.hi_fetch   = (ctrl_i[5:1] == 5'b00010);
        ev_o.byte_fetch = (ctrl_i[5:1] == 5'b10010);
        ev_o.fin_a      = (ctrl_i == CTL_FIN_A);
        ev_o.fin_b      = (ctrl_i == CTL_FIN_B);
        ev_o.phase      = ctrl_i[0];
        ev_o.dir_rd     = ctrl_i[5];
    end
endmodule

// File: rtl/blkrd_pattern.sv
module blkrd_pattern #(
    parameter int DW = 8,
    localparam int IW = DW + 1
) (
    input  logic [IW-1:0] idx_i,
    output logic [DW-1:0] byte_o
);
    logic [DW-1:0] pair;

    always_comb begin
        pair = idx_i[DW:1];
        if (idx_i[0]) begin
            byte_o = ~pair;
        end else begin
            byte_o = pair;
        end
    end
endmodule

// File: rtl/blkrd_selftest_arm.sv
module blkrd_selftest_arm
    import blkrd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          test_o
);
    typedef struct packed {
        logic [1:0] step;
        logic       on;
    } arm_t;

    arm_t arm_d, arm_q;

    logic is_ctl, is_sel;

    always_comb begin
        arm_d  = arm_q;
        is_ctl = (addr_i == AW'(REG_TEST_CTL));
        is_sel = (addr_i == AW'(REG_SRC_SEL));
        if (we_i) begin
            if (is_ctl && wdata_i == DW'(1)) begin
                arm_d.step = 2'd1;
            end else if (arm_q.step == 2'd1 && is_ctl && wdata_i == DW'(0)) begin
                arm_d.step = 2'd2;
            end else if (arm_q.step == 2'd2 && is_sel && wdata_i == DW'(SRC_PATTERN)) begin
                arm_d.step = 2'd0;
                arm_d.on   = 1'b1;
            end else begin
                arm_d.step = 2'd0;
                if (is_sel) begin
                    arm_d.on = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign test_o = arm_q.on;
endmodule

// File: rtl/blkrd_streamer.sv
module blkrd_streamer
    import blkrd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CW    = 6,
    parameter int CFG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     host_data_i,
    input  logic [CW-1:0]     host_ctrl_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [DW-1:0]     cfg_wdata_i,
    output logic              fifo_rd_en_o,
    input  logic [DW-1:0]     fifo_rd_data_i,
    output logic [DW/2-1:0]   stat_nib_o,
    output logic              stat_same_o,
    output logic              bus_oe_o,
    output logic [DW-1:0]     bus_data_o,
    output logic              done_o
);
    localparam int HW = DW / 2;
    localparam int IW = DW + 1;

    typedef struct packed {
        st_e           st;
        logic [DW-1:0] cmd;
        logic          ph;
        logic          half;
        logic [DW-1:0] cur;
        logic          mark;
        logic          last;
        logic          done;
        logic          pop;
        logic [IW-1:0] idx;
    } core_t;

    core_t   c_d, c_q;
    ctl_ev_t ev;
    logic    test_mode;
    logic [DW-1:0] pat_byte;
    logic    load;

    blkrd_ctl_decode u_dec (
        .ctrl_i (host_ctrl_i),
        .ev_o   (ev)
    );

    blkrd_pattern #(.DW(DW)) u_pat (
        .idx_i  (c_q.idx),
        .byte_o (pat_byte)
    );

    blkrd_selftest_arm #(.AW(CFG_AW), .DW(DW)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .test_o  (test_mode)
    );

    always_comb begin
        c_d     = c_q;
        c_d.pop = 1'b0;
        load    = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (host_ctrl_i == CTL_SEL) begin
                    c_d.cmd = host_data_i;
                    c_d.st  = ST_ADDR;
                end
            end

            ST_ADDR: begin
                if (host_ctrl_i == CTL_SEL) begin
                    c_d.cmd = host_data_i;
                end else if ((host_ctrl_i == CTL_NIB_GO && c_q.cmd == CMD_NIB) ||
                             (host_ctrl_i == CTL_BYTE_GO && c_q.cmd == CMD_BYTE)) begin
                    c_d.st   = (host_ctrl_i == CTL_NIB_GO) ? ST_NIB : ST_BYTE;
                    c_d.ph   = 1'b1;
                    c_d.half = 1'b0;
                    c_d.cur  = '0;
                    c_d.mark = 1'b0;
                    c_d.last = 1'b0;
                    c_d.done = 1'b0;
                    c_d.idx  = '0;
                end else begin
                    c_d.st = ST_IDLE;
                end
            end

            ST_NIB: begin
                if (host_ctrl_i == CTL_SEL) begin
                    c_d.cmd = host_data_i;
                    c_d.st  = ST_ADDR;
                end else begin
                    if (host_data_i == MARK_VAL) begin
                        c_d.mark = 1'b1;
                    end
                    if (ev.lo_fetch && ev.phase != c_q.ph && !c_q.last) begin
                        load     = 1'b1;
                        c_d.ph   = ev.phase;
                        c_d.half = 1'b0;
                        c_d.last = c_q.mark;
                    end else if (ev.lo_fetch && ev.phase == c_q.ph) begin
                        c_d.half = 1'b0;
                    end else if (ev.hi_fetch && ev.phase == c_q.ph) begin
                        c_d.half = 1'b1;
                    end
                    if (c_q.last && host_data_i == END_VAL) begin
                        c_d.done = 1'b1;
                        c_d.st   = ST_IDLE;
                    end
                end
            end

            ST_BYTE: begin
                if (!ev.dir_rd) begin
                    c_d.st = ST_IDLE;
                end else if (ev.byte_fetch && ev.phase != c_q.ph && !c_q.last) begin
                    load   = 1'b1;
                    c_d.ph = ev.phase;
                end else if (ev.fin_a && !c_q.last) begin
                    load     = 1'b1;
                    c_d.ph   = 1'b0;
                    c_d.last = 1'b1;
                end else if (ev.fin_b && c_q.last) begin
                    c_d.done = 1'b1;
                end
            end

            default: c_d.st = ST_IDLE;
        endcase

        if (load) begin
            if (test_mode) begin
                c_d.cur = pat_byte;
                c_d.idx = c_q.idx + IW'(1);
            end else begin
                c_d.cur = fifo_rd_data_i;
                c_d.pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign fifo_rd_en_o = c_q.pop;
    assign done_o       = c_q.done;
    assign bus_oe_o     = (c_q.st == ST_BYTE);
    assign bus_data_o   = (c_q.st == ST_BYTE) ? c_q.cur : '0;
    assign stat_nib_o   = (c_q.st != ST_NIB) ? '0 :
                          (c_q.half ? c_q.cur[DW-1:HW] : c_q.cur[HW-1:0]);
    assign stat_same_o  = (c_q.st == ST_NIB) && (c_q.cur[DW-1:HW] == c_q.cur[HW-1:0]);

endmodule

// File: rtl/blkrd_checker.sv
module blkrd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] host_ctrl_i,
    input logic       fifo_rd_en_o,
    input logic       bus_oe_o,
    input logic       done_o,
    input logic       test_mode
);
    // R4: a pop follows only a fetch-type control value
    assert_pop_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en_o |-> ($past(host_ctrl_i[5:1]) == 5'b00011 ||
                          $past(host_ctrl_i[5:1]) == 5'b10010 ||
                          $past(host_ctrl_i) == 6'h26));

    // R5: an unchanged control value never starts a byte
    assert_hold_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ctrl_i == $past(host_ctrl_i)) |=> !fifo_rd_en_o);

    // R6: done persists until a new start value appears
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && host_ctrl_i != 6'h03 && host_ctrl_i != 6'h25) |=> done_o);

    // R8: host no longer reading releases the bus
    assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ctrl_i[5] |=> !bus_oe_o);

    // R10: pattern source never pops the FIFO
    assert_pattern_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(test_mode) |-> !fifo_rd_en_o);
endmodule

bind blkrd_streamer blkrd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ctrl_i  (host_ctrl_i),
    .fifo_rd_en_o (fifo_rd_en_o),
    .bus_oe_o     (bus_oe_o),
    .done_o       (done_o),
    .test_mode    (test_mode)
);

// File: tb/blkrd_streamer_tb.sv
module blkrd_streamer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hdat = 8'h00;
    logic [5:0] hctl = 6'h04;
    logic       cwe = 1'b0;
    logic [4:0] cadr = '0;
    logic [7:0] cwd = '0;
    logic       rd_en;
    logic [7:0] fifo_head = 8'h00;
    logic [3:0] nib;
    logic       same;
    logic       oe;
    logic [7:0] bdat;
    logic       done;

    int nchk = 0;
    int nfail = 0;
    int pops = 0;
    logic [7:0] fq[$];

    always #5 clk = ~clk;

    blkrd_streamer dut_i (
        .clk(clk), .rst_n(rst_n), .host_data_i(hdat), .host_ctrl_i(hctl),
        .cfg_we_i(cwe), .cfg_addr_i(cadr), .cfg_wdata_i(cwd),
        .fifo_rd_en_o(rd_en), .fifo_rd_data_i(fifo_head),
        .stat_nib_o(nib), .stat_same_o(same), .bus_oe_o(oe),
        .bus_data_o(bdat), .done_o(done)
    );

    // behavioural FIFO: pop observed away from the active edge
    always @(negedge clk) begin
        if (rd_en) begin
            pops++;
            if (fq.size() > 0) void'(fq.pop_front());
        end
        fifo_head = (fq.size() > 0) ? fq[0] : 8'h00;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] c, input logic [7:0] d);
        @(negedge clk);
        hctl = c;
        hdat = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        cwe = 1'b1; cadr = a; cwd = v;
        @(negedge clk);
        cwe = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return (i % 2 == 0) ? 8'(i / 2) : 8'(8'hFF - (i - 1) / 2);
    endfunction

    task automatic nib_read(input logic [7:0] exp_q[$], input bit from_fifo);
        int p0;
        logic [5:0] ph;
        p0 = pops;
        ph = 0;
        step(6'h01, 8'h07);
        step(6'h03, 8'h07);
        step(6'h03, 8'hFF);
        for (int k = 0; k < exp_q.size(); k++) begin
            if (k == exp_q.size() - 1) step(hctl, 8'hFD);
            step(6'h06 + ph, hdat);
            check("R3 low nibble", nib, exp_q[k][3:0]);
            check("R3 same flag", same, int'(exp_q[k][7:4] == exp_q[k][3:0]));
            if (exp_q[k][7:4] != exp_q[k][3:0]) begin
                step(6'h04 + ph, hdat);
                check("R3 high nibble", nib, exp_q[k][7:4]);
            end
            check("R6 done low mid-block", done, 0);
            ph ^= 6'h01;
        end
        step(hctl, 8'h00);
        check("R6 done after end", done, 1);
        step(6'h04, 8'h00);
        check("R6 done sticky", done, 1);
        if (from_fifo) check("R4 one pop per byte", pops - p0, exp_q.size());
        else check("R10 no pops in pattern", pops - p0, 0);
    endtask

    task automatic byte_read(input logic [7:0] exp_q[$], input bit from_fifo);
        int p0;
        logic [5:0] ph;
        int n;
        p0 = pops;
        n = exp_q.size();
        ph = 0;
        step(6'h01, 8'h27);
        step(6'h25, 8'h00);
        check("R7 bus driven", oe, 1);
        check("R6 done cleared at start", done, 0);
        for (int k = 0; k < n - 1; k++) begin
            step(6'h24 + ph, 8'h00);
            check("R7 byte on bus", bdat, exp_q[k]);
            ph ^= 6'h01;
        end
        step(6'h26, 8'h00);
        check("R8 final byte", bdat, exp_q[n-1]);
        check("R8 done not yet", done, 0);
        step(6'h27, 8'h00);
        check("R8 done after final strobe", done, 1);
        step(6'h25, 8'h00);
        step(6'h04, 8'h00);
        check("R8 bus released", oe, 0);
        if (from_fifo) check("R4 byte-mode pops", pops - p0, n);
        else check("R10 byte-mode no pops", pops - p0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] e[$];
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", done, 0);
        check("R1 oe", oe, 0);
        check("R1 rd_en", rd_en, 0);
        check("R1 stat", {nib, same}, 0);

        // R2/R3/R4/R6: nibble read from FIFO, mixed and equal halves
        e = '{8'h3C, 8'h55, 8'hA7, 8'h00, 8'hF1, 8'h99};
        foreach (e[i]) fq.push_back(e[i]);
        nib_read(e, 1);

        // R2: wrong command byte does not start a stream
        fq.push_back(8'h42);
        p0 = pops;
        step(6'h01, 8'h05);
        step(6'h03, 8'h05);
        step(6'h06, 8'hFF);
        check("R2 no start on wrong command", pops - p0, 0);
        check("R2 stat idle", nib, 0);
        step(6'h04, 8'h00);
        void'(fq.pop_front());

        // R5: repeated low fetch re-presents same byte, no marker so no done
        fq.push_back(8'h8E); fq.push_back(8'h2B);
        p0 = pops;
        step(6'h01, 8'h07);
        step(6'h03, 8'hFF);
        step(6'h06, 8'hFF);
        step(6'h04, 8'hFF);
        check("R5 high before repeat", nib, 4'h8);
        step(6'h06, 8'hFF);
        check("R5 repeat shows low", nib, 4'hE);
        check("R5 repeat no pop", pops - p0, 1);
        step(6'h04, 8'hFF);
        step(6'h07, 8'hFF);
        check("R4 next byte on toggle", nib, 4'hB);
        check("R4 pops after toggle", pops - p0, 2);
        step(6'h07, 8'h00);
        check("R6 no done without marker", done, 0);
        step(6'h01, 8'h00);
        step(6'h04, 8'h00);

        // R7/R8: byte width from FIFO
        e = '{8'h11, 8'h22, 8'hFD, 8'h80, 8'h7F};
        foreach (e[i]) fq.push_back(e[i]);
        byte_read(e, 1);

        // R9/R10: arm pattern, nibble then full 512-byte read
        cfg_wr(5'h13, 8'h01);
        cfg_wr(5'h13, 8'h00);
        cfg_wr(5'h0A, 8'h11);
        e = {};
        for (int i = 0; i < 6; i++) e.push_back(pat(i));
        nib_read(e, 0);
        e = {};
        for (int i = 0; i < 512; i++) e.push_back(pat(i));
        byte_read(e, 0);

        // R11: other value to 0x0A disables pattern
        cfg_wr(5'h0A, 8'h38);
        e = '{8'hC4, 8'h6D};
        foreach (e[i]) fq.push_back(e[i]);
        byte_read(e, 1);

        // R11: out-of-order writes do not arm
        cfg_wr(5'h13, 8'h01);
        cfg_wr(5'h0A, 8'h11);
        e = '{8'h5A, 8'hA5, 8'h0F};
        foreach (e[i]) fq.push_back(e[i]);
        byte_read(e, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule